// File: doc/BRIEF.md
# Vector Dot-Product Accumulate Unit

This unit takes two multiplicand vectors and one accumulator vector, all of a fixed parameterised width. It returns a new accumulator vector. Each wide lane of the result holds the old lane value plus four unsigned products. Those products are formed from the narrow sub-lanes of the two multiplicands that sit inside that wide lane. The layout comes from one bit of a 32-bit instruction word that arrives with the operands. In the first layout, byte pairs are summed into 32-bit lanes. In the second, halfword pairs are summed into 64-bit lanes. Every lane is always updated, and each lane sum wraps to the lane width.

The same instruction word is checked against its fixed-field pattern. A word that does not match is flagged as undefined. In that case the accumulator is passed back unchanged, with the flag raised beside the valid strobe.

The pipeline has two register stages: products first, then reduction and accumulation. Each stage register is a small state machine over three named slot states: `SLOT_EMPTY` (no work), `SLOT_DOT` (a legal operation) and `SLOT_UNDEF` (a rejected word). The transitions are decided fresh on every clock:
- **Accept-legal** (valid input with a matching word) moves the first slot to `SLOT_DOT`.
- **Accept-illegal** (valid input with a non-matching word) moves it to `SLOT_UNDEF`.
- **Idle** (no valid input) moves it to `SLOT_EMPTY`.
- **Advance** copies the first slot's state into the output slot one clock later.
- **Reset** forces both slots to `SLOT_EMPTY`.

Top module: `vdot_acc_unit`

## Requirements
- R1: With instruction bit 22 = 0, output lane e (bits 32e+31:32e) equals acc lane e plus the sum, over i = 0..3, of the unsigned products of byte 4e+i of `vec_a` and `vec_b` (byte k is bits 8k+7:8k).
- R2: With instruction bit 22 = 1, output lane e (bits 64e+63:64e) equals acc lane e plus the sum, over i = 0..3, of the unsigned products of halfword 4e+i of each multiplicand (halfword k is bits 16k+15:16k).
- R3: Every lane sum wraps modulo 2^32 in byte mode and modulo 2^64 in halfword mode. A carry out of a lane never reaches its neighbour.
- R4: No lane is masked. Every lane of the vector is rewritten on every legal operation, each from its own sub-lanes only.
- R5: A word is legal only if bits 31:24 = 0x44, bit 23 = 1, bit 21 = 0, bits 15:11 = 0 and bit 10 = 1. Bits 20:16, 9:5 and 4:0 have no effect on the result.
- R6: For an illegal word, `out_undef` is 1 together with `out_valid`, and `acc_out` equals the `acc_in` that was accepted.
- R7: An input accepted on clock edge k produces `out_valid` = 1 after edge k+1. A new input can be accepted on every edge.
- R8: A synchronous active-high `rst` clears `out_valid` and `out_undef` by the next edge and discards in-flight work.
- R9: A cycle with `in_valid` = 0 gives `out_valid` = 0 two edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction word present |
| insn | input | 32 | Instruction word: field check and layout bit 22 |
| vec_a | input | VEC_W | First multiplicand vector |
| vec_b | input | VEC_W | Second multiplicand vector |
| acc_in | input | VEC_W | Old accumulator vector |
| out_valid | output | 1 | Result present |
| out_undef | output | 1 | The accepted word was illegal |
| acc_out | output | VEC_W | New accumulator vector |

## Verification
The assertions assume that `rst` is held high from time zero until the first edges have passed, and that `in_valid`, `insn` and the operand vectors carry known values whenever the unit is out of reset. They also assume that the result of an illegal word is compared only against the accumulator of that same accepted cycle. The stimulus meets these assumptions: it asserts reset first, drives every input to a defined value on the falling edge, and never leaves an input unknown once reset is released. A reset in the middle of the run is applied only while driven inputs are stable.

// File: rtl/vdot_pkg.sv
package vdot_pkg;

    // Occupancy state of one pipeline slot.
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'b00,
        SLOT_DOT   = 2'b01,
        SLOT_UNDEF = 2'b10
    } slot_t;

    // Lane layout selected by instruction bit 22.
    typedef enum logic {
        LAYOUT_B32 = 1'b0,
        LAYOUT_H64 = 1'b1
    } layout_t;

    // Bits of the word that must match a fixed pattern; the register
    // number fields and the layout bit are left out of the mask.
    localparam logic [31:0] FIXED_MASK = 32'hFFA0_FC00;
    localparam logic [31:0] FIXED_BITS = 32'h4480_0400;
    localparam int          LAYOUT_BIT = 22;

endpackage

// File: rtl/vdot_decode.sv
module vdot_decode
    import vdot_pkg::*;
(
    input  logic [31:0] insn_i,
    output logic        legal_o,
    output layout_t     layout_o
);

    always_comb begin
        legal_o  = ((insn_i & FIXED_MASK) == FIXED_BITS);
        layout_o = layout_t'(insn_i[LAYOUT_BIT]);
    end

endmodule

// File: rtl/vdot_prod_stage.sv
module vdot_prod_stage
    import vdot_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      in_valid_i,
    input  logic                      legal_i,
    input  layout_t                   layout_i,
    input  logic [VEC_W-1:0]          a_i,
    input  logic [VEC_W-1:0]          b_i,
    input  logic [VEC_W-1:0]          acc_i,
    output slot_t                     slot_o,
    output layout_t                   layout_o,
    output logic [VEC_W-1:0]          acc_o,
    output logic [VEC_W/8-1:0][15:0]  bprod_o,
    output logic [VEC_W/16-1:0][31:0] hprod_o
);

    localparam int NB = VEC_W / 8;
    localparam int NH = VEC_W / 16;

    slot_t slot_d, slot_q;
    logic [NB-1:0][15:0] bprod_d;
    logic [NH-1:0][31:0] hprod_d;

    // Byte-pair products.
    for (genvar g = 0; g < NB; g++) begin : g_bmul
        assign bprod_d[g] = {8'd0, a_i[g*8 +: 8]} * {8'd0, b_i[g*8 +: 8]};
    end

    // Halfword-pair products.
    for (genvar g = 0; g < NH; g++) begin : g_hmul
        assign hprod_d[g] = {16'd0, a_i[g*16 +: 16]} * {16'd0, b_i[g*16 +: 16]};
    end

    // Next slot state: accept-legal, accept-illegal or idle.
    always_comb begin
        unique case ({in_valid_i, legal_i})
            2'b11:   slot_d = SLOT_DOT;
            2'b10:   slot_d = SLOT_UNDEF;
            2'b01:   slot_d = SLOT_EMPTY;
            2'b00:   slot_d = SLOT_EMPTY;
            default: slot_d = SLOT_EMPTY;
        endcase
    end

    // Slot state register.
    always_ff @(posedge clk_i) begin
        if (rst_i) slot_q <= SLOT_EMPTY;
        else       slot_q <= slot_d;
    end

    // Data registers, loaded only on accepted inputs.
    always_ff @(posedge clk_i) begin
        if (in_valid_i) begin
            layout_o <= layout_i;
            acc_o    <= acc_i;
            bprod_o  <= bprod_d;
            hprod_o  <= hprod_d;
        end
    end

    assign slot_o = slot_q;

    // R7: an accepted input always occupies the first slot.
    p_accept_fills_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> (slot_q != SLOT_EMPTY));

    // R5: a word the decoder rejects is carried as undefined work.
    p_reject_marks_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && !legal_i) |=> (slot_q == SLOT_UNDEF));

endmodule

// File: rtl/vdot_reduce_stage.sv
module vdot_reduce_stage
    import vdot_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  slot_t                     slot_i,
    input  layout_t                   layout_i,
    input  logic [VEC_W-1:0]          acc_i,
    input  logic [VEC_W/8-1:0][15:0]  bprod_i,
    input  logic [VEC_W/16-1:0][31:0] hprod_i,
    output logic                      out_valid_o,
    output logic                      out_undef_o,
    output logic [VEC_W-1:0]          result_o
);

    localparam int N32 = VEC_W / 32;
    localparam int N64 = VEC_W / 64;

    slot_t            out_slot_q;
    logic [VEC_W-1:0] dot32, dot64, result_d;

    // 32-bit lanes: four byte products plus the old lane, wrapping.
    for (genvar l = 0; l < N32; l++) begin : g_lane32
        assign dot32[l*32 +: 32] = acc_i[l*32 +: 32]
                                 + {16'd0, bprod_i[4*l + 0]}
                                 + {16'd0, bprod_i[4*l + 1]}
                                 + {16'd0, bprod_i[4*l + 2]}
                                 + {16'd0, bprod_i[4*l + 3]};
    end

    // 64-bit lanes: four halfword products plus the old lane, wrapping.
    for (genvar l = 0; l < N64; l++) begin : g_lane64
        assign dot64[l*64 +: 64] = acc_i[l*64 +: 64]
                                 + {32'd0, hprod_i[4*l + 0]}
                                 + {32'd0, hprod_i[4*l + 1]}
                                 + {32'd0, hprod_i[4*l + 2]}
                                 + {32'd0, hprod_i[4*l + 3]};
    end

    // Output selection per incoming slot state.
    always_comb begin
        unique case (slot_i)
            SLOT_DOT:   result_d = (layout_i == LAYOUT_H64) ? dot64 : dot32;
            SLOT_UNDEF: result_d = acc_i;
            SLOT_EMPTY: result_d = result_o;
            default:    result_d = result_o;
        endcase
    end

    // Output slot state register (advance or reset).
    always_ff @(posedge clk_i) begin
        if (rst_i) out_slot_q <= SLOT_EMPTY;
        else       out_slot_q <= slot_i;
    end

    // Output data register.
    always_ff @(posedge clk_i) begin
        result_o <= result_d;
    end

    // Flags decoded from the output slot state.
    always_comb begin
        out_valid_o = (out_slot_q != SLOT_EMPTY);
        out_undef_o = (out_slot_q == SLOT_UNDEF);
    end

    // R7: legal work in the first slot emerges one edge later as a result.
    p_dot_emerges_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (slot_i == SLOT_DOT) |=> (out_valid_o && !out_undef_o));

    // R6: undefined work returns the accumulator untouched.
    p_undef_keeps_acc_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (slot_i == SLOT_UNDEF) |=> (out_valid_o && out_undef_o && result_o == $past(acc_i)));

    // R9: an empty slot yields no result.
    p_bubble_empty_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (slot_i == SLOT_EMPTY) |=> !out_valid_o);

endmodule

// File: rtl/vdot_acc_unit.sv
module vdot_acc_unit
    import vdot_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      insn,
    input  logic [VEC_W-1:0] vec_a,
    input  logic [VEC_W-1:0] vec_b,
    input  logic [VEC_W-1:0] acc_in,
    output logic             out_valid,
    output logic             out_undef,
    output logic [VEC_W-1:0] acc_out
);

    localparam int NB = VEC_W / 8;
    localparam int NH = VEC_W / 16;

    if (VEC_W % 64 != 0) begin : g_bad_width
        $error("VEC_W must be a multiple of 64");
    end

    logic                legal;
    layout_t             layout;
    slot_t               s1_slot;
    layout_t             s1_layout;
    logic [VEC_W-1:0]    s1_acc;
    logic [NB-1:0][15:0] s1_bprod;
    logic [NH-1:0][31:0] s1_hprod;

    vdot_decode u_decode (
        .insn_i   (insn),
        .legal_o  (legal),
        .layout_o (layout)
    );

    vdot_prod_stage #(.VEC_W(VEC_W)) u_prod (
        .clk_i      (clk),
        .rst_i      (rst),
        .in_valid_i (in_valid),
        .legal_i    (legal),
        .layout_i   (layout),
        .a_i        (vec_a),
        .b_i        (vec_b),
        .acc_i      (acc_in),
        .slot_o     (s1_slot),
        .layout_o   (s1_layout),
        .acc_o      (s1_acc),
        .bprod_o    (s1_bprod),
        .hprod_o    (s1_hprod)
    );

    vdot_reduce_stage #(.VEC_W(VEC_W)) u_reduce (
        .clk_i       (clk),
        .rst_i       (rst),
        .slot_i      (s1_slot),
        .layout_i    (s1_layout),
        .acc_i       (s1_acc),
        .bprod_i     (s1_bprod),
        .hprod_i     (s1_hprod),
        .out_valid_o (out_valid),
        .out_undef_o (out_undef),
        .result_o    (acc_out)
    );

    // R6: the undefined flag never appears without a valid result.
    p_undef_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
        out_undef |-> out_valid);

endmodule

// File: tb/test_vdot_acc_unit.sv
`timescale 1ns/1ps
module test_vdot_acc_unit;

    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [31:0]   insn = 32'd0;
    logic [VW-1:0] vec_a = '0, vec_b = '0, acc_in = '0;
    logic          out_valid, out_undef;
    logic [VW-1:0] acc_out;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    armed = 1'b0;
    string cur_tag = "R1";

    // Expected-result delay queue: index 1 is what the outputs show now.
    logic          p_v[2];
    logic          p_u[2];
    logic [VW-1:0] p_r[2];
    string         p_t[2];

    always #2.5 clk = ~clk;

    vdot_acc_unit #(.VEC_W(VW)) i_vdot_acc_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
        .vec_a(vec_a), .vec_b(vec_b), .acc_in(acc_in),
        .out_valid(out_valid), .out_undef(out_undef), .acc_out(acc_out)
    );

    function automatic logic [31:0] mk(bit half, logic [4:0] m, logic [4:0] n, logic [4:0] d);
        return {8'h44, 1'b1, half, 1'b0, m, 5'b00000, 1'b1, n, d};
    endfunction

    function automatic logic [VW-1:0] rvec();
        logic [VW-1:0] v;
        for (int k = 0; k < VW/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic model(input logic [31:0] w, input logic [VW-1:0] a, b, c,
                         output logic u, output logic [VW-1:0] r);
        longint unsigned s;
        u = !(w[31:24] == 8'h44 && w[23] == 1'b1 && w[21] == 1'b0 &&
              w[15:11] == 5'd0 && w[10] == 1'b1);
        r = c;
        if (!u && !w[22]) begin
            for (int e = 0; e < VW/32; e++) begin
                s = 64'(c[e*32 +: 32]);
                for (int i = 0; i < 4; i++)
                    s = s + 64'(a[(4*e+i)*8 +: 8]) * 64'(b[(4*e+i)*8 +: 8]);
                r[e*32 +: 32] = s[31:0];
            end
        end else if (!u) begin
            for (int e = 0; e < VW/64; e++) begin
                s = c[e*64 +: 64];
                for (int i = 0; i < 4; i++)
                    s = s + 64'(a[(4*e+i)*16 +: 16]) * 64'(b[(4*e+i)*16 +: 16]);
                r[e*64 +: 64] = s;
            end
        end
    endtask

    always @(posedge clk) begin
        logic          u;
        logic [VW-1:0] r;
        if (rst) begin
            for (int j = 0; j < 2; j++) begin
                p_v[j] = 1'b0; p_u[j] = 1'b0; p_r[j] = '0; p_t[j] = "R8";
            end
        end else begin
            p_v[1] = p_v[0]; p_u[1] = p_u[0]; p_r[1] = p_r[0]; p_t[1] = p_t[0];
            if (in_valid) begin
                model(insn, vec_a, vec_b, acc_in, u, r);
                p_v[0] = 1'b1; p_u[0] = u; p_r[0] = r; p_t[0] = cur_tag;
            end else begin
                p_v[0] = 1'b0; p_u[0] = 1'b0; p_t[0] = "R9";
            end
        end
    end

    task automatic chk(bit ok, string tag, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            chk(out_valid === p_v[1], p_v[1] ? "R7" : p_t[1], "out_valid",
                VW'(out_valid), VW'(p_v[1]));
            if (p_v[1]) begin
                chk(out_undef === p_u[1], p_t[1], "out_undef", VW'(out_undef), VW'(p_u[1]));
                chk(acc_out === p_r[1], p_t[1], "acc_out", acc_out, p_r[1]);
            end else begin
                chk(out_undef === 1'b0, p_t[1], "out_undef idle", VW'(out_undef), '0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            $display("FAIL watchdog R7 actual=%0d expected<=20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send(logic [31:0] w, logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] c);
        @(negedge clk);
        in_valid = 1'b1; insn = w; vec_a = a; vec_b = b; acc_in = c;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            insn = $urandom; vec_a = rvec(); vec_b = rvec(); acc_in = rvec();
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        armed = 1'b1;
        // R8: state straight after reset.
        chk(out_valid === 1'b0 && out_undef === 1'b0, "R8", "flags after reset",
            VW'({out_valid, out_undef}), '0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R1: byte layout, back to back.
        cur_tag = "R1";
        for (int k = 0; k < 20; k++) send(mk(1'b0, 5'($urandom), 5'($urandom), 5'($urandom)), rvec(), rvec(), rvec());
        idle(3);

        // R2: halfword layout, back to back.
        cur_tag = "R2";
        for (int k = 0; k < 20; k++) send(mk(1'b1, 5'($urandom), 5'($urandom), 5'($urandom)), rvec(), rvec(), rvec());
        idle(3);

        // R3: all-ones operands force wrap in both layouts.
        cur_tag = "R3";
        send(mk(1'b0, 5'd1, 5'd2, 5'd3), '1, '1, '1);
        send(mk(1'b1, 5'd1, 5'd2, 5'd3), '1, '1, '1);
        send(mk(1'b0, 5'd0, 5'd0, 5'd0), '1, '1, '0);
        send(mk(1'b1, 5'd0, 5'd0, 5'd0), '1, '1, {VW/64{64'hFFFF_FFFF_0000_0000}});
        idle(3);

        // R4: distinct per-lane data shows every lane is written from its own sub-lanes.
        cur_tag = "R4";
        begin
            logic [VW-1:0] ramp;
            for (int k = 0; k < VW/8; k++) ramp[k*8 +: 8] = 8'(k + 1);
            send(mk(1'b0, 5'd4, 5'd5, 5'd6), ramp, {VW/8{8'h03}}, {VW/32{32'h1000_0000}});
            send(mk(1'b1, 5'd4, 5'd5, 5'd6), ramp, ~ramp, '0);
        end
        idle(3);

        // R5: random words and legal words with one bit disturbed; register fields vary.
        cur_tag = "R5";
        for (int k = 0; k < 48; k++) begin
            logic [31:0] w;
            w = mk(1'($urandom), 5'($urandom), 5'($urandom), 5'($urandom));
            if (k % 3 == 1) w = w ^ (32'd1 << $urandom_range(31, 0));
            if (k % 3 == 2) w = $urandom;
            send(w, rvec(), rvec(), rvec());
        end
        idle(3);

        // R6: size field with its upper bit clear is undefined.
        cur_tag = "R6";
        send(mk(1'b0, 5'd7, 5'd8, 5'd9) & ~32'h0080_0000, rvec(), rvec(), rvec());
        send(mk(1'b1, 5'd7, 5'd8, 5'd9) & ~32'h0080_0000, rvec(), rvec(), rvec());
        send(32'h4480_0000, rvec(), rvec(), rvec());
        idle(3);

        // R9: bubbles between operations.
        cur_tag = "R9";
        for (int k = 0; k < 10; k++) begin
            send(mk(1'(k), 5'd1, 5'd1, 5'd1), rvec(), rvec(), rvec());
            idle(1 + (k % 2));
        end
        idle(3);

        // R8: reset with work in flight.
        cur_tag = "R8";
        send(mk(1'b0, 5'd2, 5'd2, 5'd2), rvec(), rvec(), rvec());
        send(32'h0, rvec(), rvec(), rvec());
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0 && out_undef === 1'b0, "R8", "flags after mid reset",
            VW'({out_valid, out_undef}), '0);
        rst = 1'b0;
        idle(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule